// File: doc/BRIEF.md
# Alternating Capture Buffer Tracker

The tracker sits beside a multi-channel video capture engine that writes each channel's frames into two slots in turn, slot P (index 0) and slot B (index 1). For every channel it holds the slot it expects to complete next, whether each slot currently has a frame buffer attached, whether the channel is receiving a signal, and a running frame sequence number. When the engine raises a channel's completion request, the tracker compares the engine's reported slot and the shared FIFO status word with what it expects. It then either retires the buffer with a numbered done pulse or raises a reset request for that channel.

Every fault path re-arms the channel to expect slot P. These paths are a return of signal after a loss, a FIFO overflow or corrupted-FIFO flag while a signal is present, and a slot reported out of turn. All channels are evaluated in the same cycle. The results appear on registered outputs one clock after the request. Up to eight channels are supported, because the FIFO status word carries per-channel flags at fixed bit offsets.

Top module: `pbuf_tracker`

## Requirements
- R1: After reset, and on a channel's `start_i` pulse, that channel expects slot P (`expect_slot_o` = 0) and its sequence restarts at 0. After reset all pulses and `no_signal_o` are 0. A start in the same cycle as a request takes precedence, and the request produces no pulse.
- R2: A request whose `pb_stat_i` bit equals the expected slot, with that slot occupied and no fault, gives `done_o` = 1 one cycle later. In that cycle `done_slot_o` holds the slot and `done_seq_o` holds the current sequence. The sequence then increments and the expected slot toggles.
- R3: A matching request on an unoccupied slot toggles the expected slot but gives no done pulse, and the sequence is unchanged.
- R4: A request whose `pb_stat_i` bit differs from the expected slot gives a one-cycle `reset_req_o` pulse and no done pulse, and sets the expected slot to P.
- R5: While the channel's signal-lost bit `fifo_stat_i[ch]` is 0, a request with overflow bit `fifo_stat_i[24+ch]` or bad-FIFO bit `fifo_stat_i[16+ch]` set gives a reset pulse and no done pulse, and sets the expected slot to P.
- R6: On a request that is not a recovery, `no_signal_o[ch]` takes the value of `fifo_stat_i[ch]`. While that bit is 1, the overflow and bad-FIFO bits are ignored, and the request completes normally.
- R7: A request arriving while `no_signal_o[ch]` = 1 with `fifo_stat_i[ch]` = 0 is a recovery. It clears the flag, gives a reset pulse, sets the expected slot to P, and completes nothing. The sequence is unchanged.
- R8: Channels are independent. Simultaneous requests are all resolved in one cycle, and `reset_req_o` has a bit set for each channel that faulted.
- R9: `refill_p_i[ch]` / `refill_b_i[ch]` mark slot P / B occupied, and a completion frees its slot. A refill in the same cycle as the completion of that slot leaves the slot occupied.
- R10: Without a request, a channel emits no pulse, and its expected slot and no-signal flag hold regardless of `fifo_stat_i` and `pb_stat_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | NUM_CH | Per-channel stream start: re-arm slot P, sequence 0 |
| refill_p_i | input | NUM_CH | Attach a buffer to slot P |
| refill_b_i | input | NUM_CH | Attach a buffer to slot B |
| req_i | input | NUM_CH | Per-channel completion request |
| pb_stat_i | input | NUM_CH | Slot reported by the engine (0 = P, 1 = B) |
| fifo_stat_i | input | 32 | Bit ch: signal lost; bit 16+ch: bad FIFO; bit 24+ch: overflow |
| done_o | output | NUM_CH | One-cycle buffer-done pulse |
| done_slot_o | output | NUM_CH | Slot retired by the done pulse |
| done_seq_o | output | NUM_CH*SEQ_W | Sequence number of the retired frame, channel ch at [ch*SEQ_W +: SEQ_W] |
| reset_req_o | output | NUM_CH | One-cycle channel reset request |
| no_signal_o | output | NUM_CH | Channel currently without signal |
| expect_slot_o | output | NUM_CH | Slot expected to complete next |

## Verification
On every cycle, the assertions check the following. A channel never pulses done and reset together. A reset always leaves the channel expecting slot P. A done pulse always leaves the expected slot opposite to the one retired. No pulse appears without a request in the previous cycle. A fall of the no-signal flag always comes with a reset request. Some behaviours can only be shown by the bench's scenarios, run against its own model: the exact sequence numbers, the precedence of recovery over FIFO faults over slot order, the occupancy of each slot across refills, and the muting of FIFO faults during signal loss.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;

    // Fixed layout of the shared FIFO status word
    localparam int STAT_W   = 32;
    localparam int BAD_BASE = 16;
    localparam int OVF_BASE = 24;
    localparam int MAX_CH   = 8;

    // Resolution of one channel in one cycle, in priority order
    typedef enum logic [2:0] {
        EV_IDLE     = 3'd0,
        EV_START    = 3'd1,
        EV_RECOVER  = 3'd2,
        EV_FIFO_ERR = 3'd3,
        EV_ORDER    = 3'd4,
        EV_COMPLETE = 3'd5,
        EV_SKIP     = 3'd6
    } evt_e;

    localparam logic SLOT_P = 1'b0;
    localparam logic SLOT_B = 1'b1;

endpackage

// File: rtl/pbuf_fifo_decode.sv
module pbuf_fifo_decode
    import pbuf_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [STAT_W-1:0] stat_i,
    output logic [NUM_CH-1:0] lost_o,
    output logic [NUM_CH-1:0] ovf_o,
    output logic [NUM_CH-1:0] bad_o
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_bit
        assign lost_o[g] = stat_i[g];
        assign bad_o[g]  = stat_i[BAD_BASE + g];
        assign ovf_o[g]  = stat_i[OVF_BASE + g];
    end

endmodule

// File: rtl/pbuf_classify.sv
module pbuf_classify
    import pbuf_pkg::*;
(
    input  logic start_i,
    input  logic req_i,
    input  logic pb_i,
    input  logic expect_i,
    input  logic lost_q_i,
    input  logic lost_i,
    input  logic ovf_i,
    input  logic bad_i,
    input  logic occ_hit_i,
    output evt_e evt_o
);

    always_comb begin
        evt_o = EV_IDLE;
        if (start_i) begin
            evt_o = EV_START;
        end else if (req_i) begin
            if (lost_q_i && !lost_i) begin
                evt_o = EV_RECOVER;
            end else if (!lost_i && (ovf_i || bad_i)) begin
                evt_o = EV_FIFO_ERR;
            end else if (pb_i != expect_i) begin
                evt_o = EV_ORDER;
            end else if (occ_hit_i) begin
                evt_o = EV_COMPLETE;
            end else begin
                evt_o = EV_SKIP;
            end
        end
    end

endmodule

// File: rtl/pbuf_chan.sv
module pbuf_chan
    import pbuf_pkg::*;
#(
    parameter int SEQ_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             req_i,
    input  logic             pb_i,
    input  logic             lost_i,
    input  logic             ovf_i,
    input  logic             bad_i,
    input  logic             refill_p_i,
    input  logic             refill_b_i,
    output logic             done_o,
    output logic             done_slot_o,
    output logic [SEQ_W-1:0] done_seq_o,
    output logic             reset_req_o,
    output logic             lost_o,
    output logic             expect_o
);

    typedef struct packed {
        logic             expect_slot;
        logic [SEQ_W-1:0] seq;
        logic             lost;
        logic [1:0]       occ;
        logic             done;
        logic             done_slot;
        logic [SEQ_W-1:0] done_seq;
        logic             rst_req;
    } chan_st_t;

    chan_st_t st_d, st_q;
    evt_e     evt;

    pbuf_classify u_cls (
        .start_i   (start_i),
        .req_i     (req_i),
        .pb_i      (pb_i),
        .expect_i  (st_q.expect_slot),
        .lost_q_i  (st_q.lost),
        .lost_i    (lost_i),
        .ovf_i     (ovf_i),
        .bad_i     (bad_i),
        .occ_hit_i (st_q.occ[pb_i]),
        .evt_o     (evt)
    );

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.rst_req = 1'b0;
        if (req_i && evt != EV_RECOVER && evt != EV_START) begin
            st_d.lost = lost_i;
        end
        case (evt)
            EV_START: begin
                st_d.expect_slot = SLOT_P;
                st_d.seq         = '0;
            end
            EV_RECOVER: begin
                st_d.lost        = 1'b0;
                st_d.rst_req     = 1'b1;
                st_d.expect_slot = SLOT_P;
            end
            EV_FIFO_ERR, EV_ORDER: begin
                st_d.rst_req     = 1'b1;
                st_d.expect_slot = SLOT_P;
            end
            EV_COMPLETE: begin
                st_d.done        = 1'b1;
                st_d.done_slot   = pb_i;
                st_d.done_seq    = st_q.seq;
                st_d.seq         = st_q.seq + 1'b1;
                st_d.occ[pb_i]   = 1'b0;
                st_d.expect_slot = ~st_q.expect_slot;
            end
            EV_SKIP: begin
                st_d.expect_slot = ~st_q.expect_slot;
            end
            default: ;
        endcase
        // A refill lands after the completion clears the slot
        if (refill_p_i) st_d.occ[0] = 1'b1;
        if (refill_b_i) st_d.occ[1] = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o      = st_q.done;
    assign done_slot_o = st_q.done_slot;
    assign done_seq_o  = st_q.done_seq;
    assign reset_req_o = st_q.rst_req;
    assign lost_o      = st_q.lost;
    assign expect_o    = st_q.expect_slot;

endmodule

// File: rtl/pbuf_tracker.sv
module pbuf_tracker
    import pbuf_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SEQ_W  = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [NUM_CH-1:0]       start_i,
    input  logic [NUM_CH-1:0]       refill_p_i,
    input  logic [NUM_CH-1:0]       refill_b_i,
    input  logic [NUM_CH-1:0]       req_i,
    input  logic [NUM_CH-1:0]       pb_stat_i,
    input  logic [31:0]             fifo_stat_i,
    output logic [NUM_CH-1:0]       done_o,
    output logic [NUM_CH-1:0]       done_slot_o,
    output logic [NUM_CH*SEQ_W-1:0] done_seq_o,
    output logic [NUM_CH-1:0]       reset_req_o,
    output logic [NUM_CH-1:0]       no_signal_o,
    output logic [NUM_CH-1:0]       expect_slot_o
);

    logic [NUM_CH-1:0] lost, ovf, bad;

    pbuf_fifo_decode #(.NUM_CH(NUM_CH)) u_dec (
        .stat_i (fifo_stat_i),
        .lost_o (lost),
        .ovf_o  (ovf),
        .bad_o  (bad)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pbuf_chan #(.SEQ_W(SEQ_W)) u_chan (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .start_i     (start_i[g]),
            .req_i       (req_i[g]),
            .pb_i        (pb_stat_i[g]),
            .lost_i      (lost[g]),
            .ovf_i       (ovf[g]),
            .bad_i       (bad[g]),
            .refill_p_i  (refill_p_i[g]),
            .refill_b_i  (refill_b_i[g]),
            .done_o      (done_o[g]),
            .done_slot_o (done_slot_o[g]),
            .done_seq_o  (done_seq_o[g*SEQ_W +: SEQ_W]),
            .reset_req_o (reset_req_o[g]),
            .lost_o      (no_signal_o[g]),
            .expect_o    (expect_slot_o[g])
        );
    end

endmodule

// File: rtl/pbuf_tracker_chk.sv
module pbuf_tracker_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NUM_CH-1:0] start_i,
    input logic [NUM_CH-1:0] req_i,
    input logic [NUM_CH-1:0] done_o,
    input logic [NUM_CH-1:0] done_slot_o,
    input logic [NUM_CH-1:0] reset_req_o,
    input logic [NUM_CH-1:0] no_signal_o,
    input logic [NUM_CH-1:0] expect_slot_o
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_a
        AST_DONE_RESET_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(done_o[g] && reset_req_o[g])); // R4
        AST_RESET_ARMS_P: assert property (@(posedge clk_i) disable iff (!rst_ni)
            reset_req_o[g] |-> !expect_slot_o[g]); // R4
        AST_DONE_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            done_o[g] |-> expect_slot_o[g] != done_slot_o[g]); // R2
        AST_QUIET_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !$past(req_i[g]) |-> !done_o[g] && !reset_req_o[g]); // R10
        AST_RECOVER_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(no_signal_o[g]) |-> reset_req_o[g]); // R7
    end

endmodule

bind pbuf_tracker pbuf_tracker_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .req_i         (req_i),
    .done_o        (done_o),
    .done_slot_o   (done_slot_o),
    .reset_req_o   (reset_req_o),
    .no_signal_o   (no_signal_o),
    .expect_slot_o (expect_slot_o)
);

// File: tb/pbuf_tracker_test.sv
module pbuf_tracker_test;

    localparam int N  = 8;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  start = '0, refill_p = '0, refill_b = '0, req = '0, pb = '0;
    logic [31:0]   fifo = '0;
    logic [N-1:0]  done, dslot, rreq, nosig, expslot;
    logic [N*SW-1:0] dseq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pbuf_tracker #(.NUM_CH(N), .SEQ_W(SW)) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .refill_p_i(refill_p),
        .refill_b_i(refill_b), .req_i(req), .pb_stat_i(pb), .fifo_stat_i(fifo),
        .done_o(done), .done_slot_o(dslot), .done_seq_o(dseq),
        .reset_req_o(rreq), .no_signal_o(nosig), .expect_slot_o(expslot)
    );

    // Behavioural reference model
    int m_exp[N], m_seq[N], m_nos[N], m_occp[N], m_occb[N];
    int m_done[N], m_slot[N], m_dseq[N], m_rst[N];

    always @(posedge clk) begin
        for (int c = 0; c < N; c++) begin
            if (!rst_n) begin
                m_exp[c] = 0; m_seq[c] = 0; m_nos[c] = 0; m_occp[c] = 0; m_occb[c] = 0;
                m_done[c] = 0; m_slot[c] = 0; m_dseq[c] = 0; m_rst[c] = 0;
            end else begin
                m_done[c] = 0; m_rst[c] = 0;
                if (start[c]) begin
                    m_exp[c] = 0; m_seq[c] = 0;
                end else if (req[c]) begin
                    if (m_nos[c] == 1 && fifo[c] == 0) begin
                        m_nos[c] = 0; m_rst[c] = 1; m_exp[c] = 0;
                    end else begin
                        m_nos[c] = int'(fifo[c]);
                        if (fifo[c] == 0 && (fifo[24+c] || fifo[16+c])) begin
                            m_rst[c] = 1; m_exp[c] = 0;
                        end else if (int'(pb[c]) != m_exp[c]) begin
                            m_rst[c] = 1; m_exp[c] = 0;
                        end else begin
                            if ((pb[c] ? m_occb[c] : m_occp[c]) == 1) begin
                                m_done[c] = 1; m_slot[c] = int'(pb[c]); m_dseq[c] = m_seq[c];
                                m_seq[c] = (m_seq[c] + 1) % 65536;
                                if (pb[c]) m_occb[c] = 0; else m_occp[c] = 0;
                            end
                            m_exp[c] = 1 - m_exp[c];
                        end
                    end
                end
                if (refill_p[c]) m_occp[c] = 1;
                if (refill_b[c]) m_occb[c] = 1;
            end
        end
    end

    task automatic chk(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < N; c++) begin
                chk("R2 model done",      int'(done[c]), m_done[c]);
                chk("R4 model reset_req", int'(rreq[c]), m_rst[c]);
                chk("R6 model no_signal", int'(nosig[c]), m_nos[c]);
                chk("R1 model expect",    int'(expslot[c]), m_exp[c]);
                if (m_done[c] == 1) begin
                    chk("R2 model slot", int'(dslot[c]), m_slot[c]);
                    chk("R2 model seq",  int'(dseq[c*SW +: SW]), m_dseq[c]);
                end
            end
        end
    end

    task automatic cyc();
        @(negedge clk);
        #2;
        start = '0; refill_p = '0; refill_b = '0; req = '0; pb = '0; fifo = '0;
    endtask

    task automatic fill(int c);
        refill_p[c] = 1'b1; refill_b[c] = 1'b1;
        cyc();
    endtask

    task automatic hit(int c, logic s, logic [31:0] f);
        req[c] = 1'b1; pb[c] = s; fifo = f;
        cyc();
    endtask

    initial begin
        #200000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        chk("R1 reset done",   int'(done), 0);
        chk("R1 reset rreq",   int'(rreq), 0);
        chk("R1 reset nosig",  int'(nosig), 0);
        chk("R1 reset expect", int'(expslot), 0);

        // R2 normal alternation on channel 0
        fill(0);
        hit(0, 1'b0, 32'h0);
        chk("R2 done",   int'(done[0]), 1);
        chk("R2 slot",   int'(dslot[0]), 0);
        chk("R2 seq",    int'(dseq[15:0]), 0);
        chk("R2 expect", int'(expslot[0]), 1);
        hit(0, 1'b1, 32'h0);
        chk("R2 seq B",  int'(dseq[15:0]), 1);
        chk("R2 slot B", int'(dslot[0]), 1);

        // R3 empty slots: toggle only
        hit(0, 1'b0, 32'h0);
        chk("R3 empty done",   int'(done[0]), 0);
        chk("R3 empty expect", int'(expslot[0]), 1);

        // R4 order mismatch
        fill(0);
        hit(0, 1'b0, 32'h0);
        chk("R4 mismatch reset",  int'(rreq[0]), 1);
        chk("R4 mismatch done",   int'(done[0]), 0);
        chk("R4 mismatch expect", int'(expslot[0]), 0);
        hit(0, 1'b0, 32'h0);
        chk("R3 seq unchanged",   int'(dseq[15:0]), 2);

        // R5 overflow and bad FIFO with signal
        hit(0, 1'b1, 32'h0);
        chk("R5 pre expect", int'(expslot[0]), 0);
        fill(0);
        hit(0, 1'b1, 32'h0);
        hit(0, 1'b0, 32'h0100_0000);
        chk("R5 overflow reset", int'(rreq[0]), 1);
        chk("R5 overflow done",  int'(done[0]), 0);
        hit(0, 1'b0, 32'h0001_0000);
        chk("R5 bad reset", int'(rreq[0]), 1);

        // R6 no signal: FIFO faults ignored, completes
        hit(0, 1'b0, 32'h0101_0001);
        chk("R6 nosig flag", int'(nosig[0]), 1);
        chk("R6 nosig reset", int'(rreq[0]), 0);
        chk("R6 nosig done", int'(done[0]), 1);

        // R7 recovery
        hit(0, 1'b1, 32'h0);
        chk("R7 recover flag",   int'(nosig[0]), 0);
        chk("R7 recover reset",  int'(rreq[0]), 1);
        chk("R7 recover done",   int'(done[0]), 0);
        chk("R7 recover expect", int'(expslot[0]), 0);

        // R8 parallel channels
        fill(2); fill(5);
        req[2] = 1'b1; req[5] = 1'b1; pb[5] = 1'b1;
        cyc();
        chk("R8 vector reset", int'(rreq), 32);
        chk("R8 vector done",  int'(done), 4);

        // R9 refill in the completion cycle
        fill(3);
        req[3] = 1'b1; refill_p[3] = 1'b1;
        cyc();
        hit(3, 1'b1, 32'h0);
        hit(3, 1'b0, 32'h0);
        chk("R9 refilled slot done", int'(done[3]), 1);
        chk("R9 refilled slot seq",  int'(dseq[3*SW +: SW]), 2);

        // R1 start beats a request
        fill(0);
        start[0] = 1'b1; req[0] = 1'b1;
        cyc();
        chk("R1 start no done",  int'(done[0]), 0);
        chk("R1 start expect",   int'(expslot[0]), 0);
        hit(0, 1'b0, 32'h0);
        chk("R1 start seq zero", int'(dseq[15:0]), 0);

        // R10 no request: nothing moves
        fifo = 32'hFFFF_FFFF; pb = '1;
        cyc();
        chk("R10 idle done",   int'(done), 0);
        chk("R10 idle rreq",   int'(rreq), 0);
        chk("R10 idle nosig",  int'(nosig), 0);
        chk("R10 idle expect", int'(expslot[0]), 1);

        repeat (3) cyc();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule